// File: doc/BRIEF.md
# Dual 8-bit Parallel Port with Per-Pin Direction

This block sits on a processor's byte-wide bus and presents two 8-bit parallel ports, called A and B. Each port has a data (output) register and a direction register. Every pin's direction is set by its own direction bit. A pin programmed as an output drives the value held in the data register and has its output enable raised. A pin programmed as an input is sampled when the data register is read.

The block is selected by a pair of chip-select inputs: one active high and one active low. With this pair, a small system can wire two address lines straight to the block and avoid extra decode logic. Four register-select lines pick one of sixteen locations. Only four of those locations hold storage. The two data registers sit at adjacent offsets, so software can fetch both ports as a single 16-bit word. The block also produces a decode strobe for offset C, for use by a separate control-line block.

Writes take effect on the rising clock edge. Read data is combinational from the current bus request and the current pin levels.

Top module: `dual_pport`

## Requirements
- R1: The block is selected only when `cs_hi`=1 and `cs_lo_n`=0. With any other combination, a write changes no register and `rdata` is 0.
- R2: A selected write (`rd_wr_n`=0) at offset 0 loads the port B data register. At offset 1 it loads the port A data register. The new value appears from the next clock.
- R3: A selected write at offset 2 loads the port B direction register, and at offset 3 the port A direction register. A selected read (`rd_wr_n`=1) at these offsets returns the stored value.
- R4: For each port and each bit i, `*_pin_oe[i]` equals direction bit i. `*_pin_out[i]` equals data-register bit i.
- R5: A selected read at offset 0 (port B) or offset 1 (port A) returns, per bit i, the data-register bit when direction bit i is 1, and the live pin input when it is 0.
- R6: Asynchronous active-low reset clears both data registers and both direction registers. After reset all pins are inputs with output enable 0 and output value 0.
- R7: Selected reads of offsets 4 to 15 return 0. Selected writes to them change no register.
- R8: `ctl_sel` is 1 exactly when the block is selected and `reg_sel`=4'hC, for either read or write.
- R9: `rdata` is 0 during any selected write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 4 | Register offset |
| wdata | input | 8 | Write data from processor |
| rdata | output | 8 | Read data to processor |
| a_pin_in | input | 8 | Port A pin levels |
| a_pin_out | output | 8 | Port A drive values |
| a_pin_oe | output | 8 | Port A output enables |
| b_pin_in | input | 8 | Port B pin levels |
| b_pin_out | output | 8 | Port B drive values |
| b_pin_oe | output | 8 | Port B output enables |
| ctl_sel | output | 1 | Decode strobe for offset C |

## Verification
The assertions check several properties on every cycle:
- Registers hold whenever their write strobe is low.
- At most one write strobe fires at a time.
- `ctl_sel` never rises without chip select.
- Read data is zero in write cycles and at unimplemented offsets.
- Each readback bit follows the data register for output pins and the pin for input pins.

The bench's reference model covers what only scenarios can show. This includes the mapping of each offset to the right port, and the blocking of writes by each wrong chip-select combination. It also covers reading both ports back to back as a word while random pin levels change, and the clearing effect of a reset issued mid-run.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PORT_W  = 8;
  localparam int SEL_W   = 4;
  localparam int NUM_REG = 4;

  // Offsets whose order is visible to software
  localparam logic [SEL_W-1:0] OFS_B_DATA = 4'h0;
  localparam logic [SEL_W-1:0] OFS_A_DATA = 4'h1;
  localparam logic [SEL_W-1:0] OFS_B_DIR  = 4'h2;
  localparam logic [SEL_W-1:0] OFS_A_DIR  = 4'h3;
  localparam logic [SEL_W-1:0] OFS_CTL    = 4'hC;

  // Per-bit merge of driven value and sampled pin, chosen by direction
  function automatic logic [PORT_W-1:0] port_readback(
    input logic [PORT_W-1:0] drive_q,
    input logic [PORT_W-1:0] dir_q,
    input logic [PORT_W-1:0] pin_lvl
  );
    return (drive_q & dir_q) | (pin_lvl & ~dir_q);
  endfunction

  function automatic logic chip_enabled(input logic hi, input logic lo_n);
    return hi & ~lo_n;
  endfunction
endpackage

// File: rtl/pport_decode.sv
module pport_decode
  import pport_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int NR = NUM_REG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          rd_wr_n,
  input  logic [SW-1:0] reg_sel,
  output logic          chip_sel,
  output logic          rd_en,
  output logic [NR-1:0] wr_stb,
  output logic          impl_hit,
  output logic          ctl_sel
);
  logic wr_en;

  assign chip_sel = chip_enabled(cs_hi, cs_lo_n);
  assign rd_en    = chip_sel & rd_wr_n;
  assign wr_en    = chip_sel & ~rd_wr_n;
  assign impl_hit = (reg_sel < SW'(NR));
  assign ctl_sel  = chip_sel & (reg_sel == OFS_CTL);

  for (genvar g = 0; g < NR; g++) begin : g_stb
    assign wr_stb[g] = wr_en & (reg_sel == SW'(g));
  end

  assert_stb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  assert_ctl_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel |-> (cs_hi && !cs_lo_n));

  assert_no_stb_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_hi && !cs_lo_n) |-> (wr_stb == '0));
endmodule

// File: rtl/pport_port.sv
module pport_port
  import pport_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] data_rd,
  output logic [W-1:0] dir_rd
);
  logic [W-1:0] drive_q;
  logic [W-1:0] dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= '0;
    end else begin
      if (data_we) drive_q <= wdata;
      if (dir_we)  dir_q   <= wdata;
    end
  end

  assign pin_out = drive_q;
  assign pin_oe  = dir_q;
  assign dir_rd  = dir_q;
  assign data_rd = port_readback(drive_q, dir_q, pin_in);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(pin_out));

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(pin_oe));

  assert_reset_clear_R6: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0 && pin_oe == '0));

  for (genvar b = 0; b < W; b++) begin : g_chk
    always_comb begin
      if (rst_n) begin
        assert_bit_mix_R5: assert (dir_q[b] ? (data_rd[b] == pin_out[b])
                                            : (data_rd[b] == pin_in[b]));
      end
    end
  end
endmodule

// File: rtl/dual_pport.sv
module dual_pport
  import pport_pkg::*;
#(
  parameter int W  = PORT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          rd_wr_n,
  input  logic [SW-1:0] reg_sel,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  a_pin_in,
  output logic [W-1:0]  a_pin_out,
  output logic [W-1:0]  a_pin_oe,
  input  logic [W-1:0]  b_pin_in,
  output logic [W-1:0]  b_pin_out,
  output logic [W-1:0]  b_pin_oe,
  output logic          ctl_sel
);
  localparam int NR = NUM_REG;

  logic          chip_sel, rd_en, impl_hit;
  logic [NR-1:0] wr_stb;
  logic [W-1:0]  a_data_rd, a_dir_rd, b_data_rd, b_dir_rd;
  logic [W-1:0]  reg_view;

  pport_decode #(.SW(SW), .NR(NR)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .rd_wr_n(rd_wr_n), .reg_sel(reg_sel), .chip_sel(chip_sel),
    .rd_en(rd_en), .wr_stb(wr_stb), .impl_hit(impl_hit), .ctl_sel(ctl_sel)
  );

  pport_port #(.W(W)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .data_we(wr_stb[OFS_A_DATA]), .dir_we(wr_stb[OFS_A_DIR]),
    .wdata(wdata), .pin_in(a_pin_in), .pin_out(a_pin_out), .pin_oe(a_pin_oe),
    .data_rd(a_data_rd), .dir_rd(a_dir_rd)
  );

  pport_port #(.W(W)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .data_we(wr_stb[OFS_B_DATA]), .dir_we(wr_stb[OFS_B_DIR]),
    .wdata(wdata), .pin_in(b_pin_in), .pin_out(b_pin_out), .pin_oe(b_pin_oe),
    .data_rd(b_data_rd), .dir_rd(b_dir_rd)
  );

  always_comb begin
    unique case (reg_sel[1:0])
      OFS_B_DATA[1:0]: reg_view = b_data_rd;
      OFS_A_DATA[1:0]: reg_view = a_data_rd;
      OFS_B_DIR[1:0]:  reg_view = b_dir_rd;
      default:         reg_view = a_dir_rd;
    endcase
  end

  assign rdata = (rd_en && impl_hit) ? reg_view : '0;

  assert_rd_zero_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !rd_wr_n) |-> (rdata == '0));

  assert_rd_zero_unimpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !impl_hit |-> (rdata == '0));

  assert_rd_zero_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |-> (rdata == '0));
endmodule

// File: tb/dual_pport_tb_top.sv
module dual_pport_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_hi = 1'b0, cs_lo_n = 1'b1, rd_wr_n = 1'b1;
  logic [3:0] reg_sel = '0;
  logic [7:0] wdata = '0, a_pin_in = '0, b_pin_in = '0;
  logic [7:0] rdata, a_pin_out, a_pin_oe, b_pin_out, b_pin_oe;
  logic       ctl_sel;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_ora = 0, m_orb = 0, m_dda = 0, m_ddb = 0;

  always #2 clk = ~clk;

  dual_pport dut_i (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .rd_wr_n(rd_wr_n), .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
    .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
    .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
    .ctl_sel(ctl_sel)
  );

  function automatic int mix(int drv, int dir, int pin);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      if ((dir >> i) & 1) r += ((drv >> i) & 1) << i;
      else                r += ((pin >> i) & 1) << i;
    end
    return r;
  endfunction

  function automatic int model_read(int ofs);
    case (ofs)
      0: return mix(m_orb, m_ddb, int'(b_pin_in));
      1: return mix(m_ora, m_dda, int'(a_pin_in));
      2: return m_ddb;
      3: return m_dda;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    bit sel = (cs_hi === 1'b1) && (cs_lo_n === 1'b0);
    int exp_rd = (sel && rd_wr_n) ? model_read(int'(reg_sel)) : 0;
    check(tag, "rdata", int'(rdata), exp_rd);
    check("R4", "a_pin_out", int'(a_pin_out), m_ora);
    check("R4", "a_pin_oe",  int'(a_pin_oe),  m_dda);
    check("R4", "b_pin_out", int'(b_pin_out), m_orb);
    check("R4", "b_pin_oe",  int'(b_pin_oe),  m_ddb);
    check("R8", "ctl_sel", int'(ctl_sel), (sel && reg_sel == 4'hC) ? 1 : 0);
  endtask

  task automatic cyc(bit hi, bit lo_n, bit rd, int ofs, int wd, string tag);
    bit sel;
    @(negedge clk);
    cs_hi = hi; cs_lo_n = lo_n; rd_wr_n = rd;
    reg_sel = 4'(ofs); wdata = 8'(wd);
    a_pin_in = 8'($urandom()); b_pin_in = 8'($urandom());
    #1 compare_all(tag);
    sel = hi && !lo_n;
    @(posedge clk);
    if (sel && !rd) begin
      case (ofs)
        0: m_orb = wd & 255;
        1: m_ora = wd & 255;
        2: m_ddb = wd & 255;
        3: m_dda = wd & 255;
        default: ;
      endcase
    end
  endtask

  task automatic wr(int ofs, int wd, string tag); cyc(1, 0, 0, ofs, wd, tag); endtask
  task automatic rd(int ofs, string tag);         cyc(1, 0, 1, ofs, 0, tag);  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R6: outputs clear while in reset
    repeat (3) @(negedge clk);
    #1 compare_all("R6");
    rst_n = 1'b1;
    for (int o = 0; o < 4; o++) rd(o, "R6");

    // R3: directions
    wr(2, 'h0F, "R9"); wr(3, 'hA5, "R9");
    rd(2, "R3"); rd(3, "R3");
    // R2 + R5: data with mixed directions, both ports back to back
    wr(0, 'h3C, "R9"); wr(1, 'hC3, "R9");
    for (int k = 0; k < 6; k++) begin rd(0, "R5"); rd(1, "R5"); end
    wr(2, 'hFF, "R2"); wr(3, 'hFF, "R2");
    rd(0, "R2"); rd(1, "R2");
    wr(2, 'h00, "R5"); wr(3, 'h00, "R5");
    rd(0, "R5"); rd(1, "R5");

    // R1: wrong chip-select pairs block writes and reads
    for (int o = 0; o < 4; o++) begin
      cyc(0, 0, 0, o, 'h5A, "R1");
      cyc(1, 1, 0, o, 'h5A, "R1");
      cyc(0, 1, 0, o, 'h5A, "R1");
      cyc(0, 1, 1, o, 0, "R1");
      rd(o, "R1");
    end

    // R7: unimplemented offsets
    for (int o = 4; o < 16; o++) begin
      wr(o, 'hE7, "R7");
      rd(o, "R7");
      for (int q = 0; q < 4; q++) rd(q, "R7");
    end

    // R8: control decode, read and write, and deselected
    rd(12, "R8"); wr(12, 'h11, "R8"); cyc(0, 0, 1, 12, 0, "R8");

    // random traffic
    for (int n = 0; n < 400; n++)
      cyc($urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
          1'($urandom()), int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), "R5");

    // R6: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    m_ora = 0; m_orb = 0; m_dda = 0; m_ddb = 0;
    @(negedge clk); #1 compare_all("R6");
    rst_n = 1'b1;
    for (int o = 0; o < 4; o++) rd(o, "R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule